// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block sits between a serial receiver and the host side of a UART. Each time the receiver finishes a character, it pushes the data word and three status flags into a small circular queue: parity error, framing error and received break. The host reads the oldest character through a data-read strobe, which pops it. The status outputs can be sampled as often as wanted without changing the queue. The block reports whether data is waiting and whether the queue is full. It latches an overrun when a character arrives that cannot be stored.

Error reporting has two modes:
- **Per-character mode:** the flags shown belong to the character now at the head of the queue.
- **Accumulating mode:** the flags shown are the OR of every character that has reached the head since the host last cleared errors.

A receiver flush command realigns the read and write pointers and marks the queue empty. It leaves the stored words in place.

The block also drives an optional automatic request-to-send line. The line drops when a new start bit is seen while no entry is free, and it rises again once room appears.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset, `ready_o`=0, `full_o`=0, `overrun_o`=0, `rts_o`=1, `stat_o`=0 and `rd_data_o`=0.
- R2: `ready_o` is 1 while at least one character is queued, and `full_o` is 1 while all DEPTH (default 3) entries are occupied.
- R3: `rd_data_o` shows the word at the read pointer. A pop (`pop_i`) advances the read pointer, and characters come out in arrival order.
- R4: Status flag positions are bit 0 parity error, bit 1 framing error and bit 2 break. With `blk_mode_i`=0, `stat_o` is the stored status of the entry at the read pointer.
- R5: With `blk_mode_i`=1, `stat_o` is the OR of the status of every character that became head since the last `err_rst_i`. A character becomes head either by being pushed into an empty queue or by being exposed through a pop. `err_rst_i` clears this OR, but a character arriving in that same cycle is still included.
- R6: A character pushed into an empty, aligned queue has its status visible in `stat_o` in the same cycle in which `ready_o` first reads 1.
- R7: `rx_rst_i` takes priority over push and pop, and its effects are seen from the next cycle:
  - the read pointer is set to the write pointer and the queue reads empty;
  - the stored status of that entry becomes 0;
  - the data words are not cleared.
- R8: With `auto_rts_i`=1, `rts_o` drops to 0 in the cycle after `start_det_i` is seen while full, and returns to 1 in the cycle after the queue is not full. With `auto_rts_i`=0, `rts_o` is 1.
- R9: A push while full and with no pop in the same cycle is dropped and sets `overrun_o`. Only `err_rst_i` clears `overrun_o`, and a new overrun in the same cycle wins over the clear.
- R10: A pop of an empty queue still advances the read pointer, so later reads return stale words until `rx_rst_i` realigns the pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Receiver delivers a character |
| push_data_i | input | DATA_W | Received character word |
| push_stat_i | input | 3 | Status of the received character {break, framing, parity} |
| pop_i | input | 1 | Host data read, pops the head |
| err_rst_i | input | 1 | Clear accumulated errors and overrun |
| rx_rst_i | input | 1 | Receiver flush: realign pointers |
| blk_mode_i | input | 1 | 1 = accumulating status, 0 = per character |
| auto_rts_i | input | 1 | Enable automatic request-to-send control |
| start_det_i | input | 1 | Receiver saw a valid start bit |
| rd_data_o | output | DATA_W | Head word |
| stat_o | output | 3 | Reported error status |
| ready_o | output | 1 | At least one character queued |
| full_o | output | 1 | All entries occupied |
| overrun_o | output | 1 | Sticky overrun flag |
| rts_o | output | 1 | Request-to-send, 1 = asserted |

## Verification
A wrong pointer or count shows up at once:
- `ready_o` or `full_o` disagrees in the next cycle;
- `rd_data_o` presents the wrong word at the following read.

A pointer misalignment can stay hidden until the next push into an empty queue, which is why the bench drives empty pops and flushes before fresh pushes.

A faulty status accumulator or overrun flag only appears in `stat_o` or `overrun_o` after the next arrival or clear. For that reason these outputs are compared every cycle against an independent model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int ST_W   = 3;
   localparam int ST_PAR = 0;
   localparam int ST_FRM = 1;
   localparam int ST_BRK = 2;
   typedef logic [ST_W-1:0] rxq_stat_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 3,
   parameter int DATA_W = 8,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  rxq_stat_t         push_stat,
   input  logic              pop,
   input  logic              rx_rst,
   output logic              push_ok,
   output logic [CW-1:0]     cnt,
   output logic [DATA_W-1:0] head_data,
   output rxq_stat_t         head_stat,
   output rxq_stat_t         next_stat
);
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

   logic [DATA_W-1:0] data_q [DEPTH];
   rxq_stat_t         stat_q [DEPTH];
   logic [PW-1:0]     rd_q, wr_q, rd_inc, wr_inc;
   logic [CW-1:0]     cnt_q;
   logic              pop_dec;

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign rd_inc = rd_q + 1'b1;
         assign wr_inc = wr_q + 1'b1;
      end else begin : g_wrap
         assign rd_inc = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_inc = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   assign push_ok = push && !rx_rst && ((cnt_q != CNT_MAX) || pop);
   assign pop_dec = pop && !rx_rst && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (rx_rst) begin
         rd_q  <= wr_q;
         cnt_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_inc;
         if (pop)     rd_q <= rd_inc;
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_dec);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            data_q[i] <= '0;
            stat_q[i] <= '0;
         end
      end else if (rx_rst) begin
         stat_q[wr_q] <= '0;
      end else if (push_ok) begin
         data_q[wr_q] <= push_data;
         stat_q[wr_q] <= push_stat;
      end
   end

   assign cnt       = cnt_q;
   assign head_data = data_q[rd_q];
   assign head_stat = stat_q[rd_q];
   assign next_stat = stat_q[rd_inc];

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
   p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |=> (cnt_q == '0) && (rd_q == wr_q));
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !rx_rst && !pop && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX) && $stable(wr_q));
   p_empty_pop_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !rx_rst && cnt_q == '0) |=> (rd_q != $past(rd_q)));
endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
   import rxq_pkg::*;
#(
   parameter int DEPTH = 3,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blk_mode,
   input  logic          err_rst,
   input  logic          push,
   input  logic          push_ok,
   input  rxq_stat_t     push_stat,
   input  logic          pop,
   input  logic          rx_rst,
   input  logic [CW-1:0] cnt,
   input  rxq_stat_t     head_stat,
   input  rxq_stat_t     next_stat,
   output rxq_stat_t     stat_o,
   output logic          overrun_o
);
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

   rxq_stat_t acc_q, arrive;
   logic      ovr_q, ovr_set;

   always_comb begin
      arrive = '0;
      if (push_ok && ((cnt == '0) || ((cnt == CW'(1)) && pop)))
         arrive = push_stat;
      else if (pop && !rx_rst && (cnt >= CW'(2)))
         arrive = next_stat;
   end

   assign ovr_set = push && !rx_rst && !pop && (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         acc_q <= (err_rst ? '0 : acc_q) | arrive;
         if (ovr_set)      ovr_q <= 1'b1;
         else if (err_rst) ovr_q <= 1'b0;
      end
   end

   assign stat_o    = blk_mode ? acc_q : head_stat;
   assign overrun_o = ovr_q;

   p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_set |=> ovr_q);
   p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !err_rst) |=> ovr_q);
   p_acc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !err_rst |=> ((acc_q & $past(acc_q)) == $past(acc_q)));
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic start_det,
   input  logic is_full,
   output logic rts_o
);
   logic rts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rts_q <= 1'b1;
      else if (!auto_en)             rts_q <= 1'b1;
      else if (start_det && is_full) rts_q <= 1'b0;
      else if (!is_full)             rts_q <= 1'b1;
   end

   assign rts_o = rts_q;

   p_rts_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && start_det && is_full) |=> !rts_q);
   p_rts_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> rts_q);
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic [2:0]        push_stat_i,
   input  logic              pop_i,
   input  logic              err_rst_i,
   input  logic              rx_rst_i,
   input  logic              blk_mode_i,
   input  logic              auto_rts_i,
   input  logic              start_det_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [2:0]        stat_o,
   output logic              ready_o,
   output logic              full_o,
   output logic              overrun_o,
   output logic              rts_o
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_status_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_status_fifo: DATA_W must be positive");
      end
   endgenerate

   logic          push_ok;
   logic [CW-1:0] cnt;
   rxq_stat_t     head_stat, next_stat, rep_stat;

   rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push_i), .push_data(push_data_i),
      .push_stat(push_stat_i), .pop(pop_i), .rx_rst(rx_rst_i),
      .push_ok(push_ok), .cnt(cnt), .head_data(rd_data_o),
      .head_stat(head_stat), .next_stat(next_stat)
   );

   rxq_errstat #(.DEPTH(DEPTH)) u_stat (
      .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode_i), .err_rst(err_rst_i),
      .push(push_i), .push_ok(push_ok), .push_stat(push_stat_i), .pop(pop_i),
      .rx_rst(rx_rst_i), .cnt(cnt), .head_stat(head_stat),
      .next_stat(next_stat), .stat_o(rep_stat), .overrun_o(overrun_o)
   );

   assign ready_o = (cnt != '0);
   assign full_o  = (cnt == CW'(DEPTH));
   assign stat_o  = rep_stat;

   rxq_flow u_flow (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_i), .start_det(start_det_i),
      .is_full(full_o), .rts_o(rts_o)
   );

   p_ready_after_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !rx_rst_i) |=> ready_o);
   p_flush_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst_i |=> !ready_o);
endmodule

// File: tb/rx_status_fifo_test.sv
module rx_status_fifo_test;
   localparam int DEPTH = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic push = 0, pop = 0, errr = 0, rxr = 0, blk = 0, auto_r = 0, sdet = 0;
   logic [7:0] pdata = '0;
   logic [2:0] pstat = '0;
   logic [7:0] rd_data;
   logic [2:0] stat;
   logic ready, full, ovr, rts;

   int n_chk = 0, n_fail = 0;

   // reference model
   logic [7:0] mmem [DEPTH];
   logic [2:0] mst  [DEPTH];
   int mrd = 0, mwr = 0, mcnt = 0;
   logic [2:0] macc = '0;
   logic movr = 0, mrts = 1;

   always #10 clk = ~clk;

   rx_status_fifo uut (
      .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(pdata),
      .push_stat_i(pstat), .pop_i(pop), .err_rst_i(errr), .rx_rst_i(rxr),
      .blk_mode_i(blk), .auto_rts_i(auto_r), .start_det_i(sdet),
      .rd_data_o(rd_data), .stat_o(stat), .ready_o(ready), .full_o(full),
      .overrun_o(ovr), .rts_o(rts)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int nx(input int p);
      return (p + 1) % DEPTH;
   endfunction

   function automatic logic [2:0] exp_stat();
      return blk ? macc : mst[mrd];
   endfunction

   task automatic model_step();
      bit mfull, ok, dec;
      logic [2:0] arr;
      mfull = (mcnt == DEPTH);
      ok  = push && !rxr && (!mfull || pop);
      dec = pop && !rxr && (mcnt != 0);
      arr = '0;
      if (ok && (mcnt == 0 || (mcnt == 1 && pop))) arr = pstat;
      else if (pop && !rxr && mcnt >= 2)           arr = mst[nx(mrd)];
      macc = (errr ? 3'b000 : macc) | arr;
      if (push && !rxr && mfull && !pop) movr = 1;
      else if (errr)                     movr = 0;
      if (!auto_r)              mrts = 1;
      else if (sdet && mfull)   mrts = 0;
      else if (!mfull)          mrts = 1;
      if (rxr) begin
         mst[mwr] = '0;
         mrd = mwr;
         mcnt = 0;
      end else begin
         if (ok) begin
            mmem[mwr] = pdata;
            mst[mwr] = pstat;
            mwr = nx(mwr);
         end
         if (pop) mrd = nx(mrd);
         mcnt = mcnt + int'(ok) - int'(dec);
      end
   endtask

   task automatic compare();
      chk(ready == (mcnt != 0), "R2", "ready", ready, mcnt != 0);
      chk(full == (mcnt == DEPTH), "R2", "full", full, mcnt == DEPTH);
      chk(rd_data == mmem[mrd], "R3", "rd_data", rd_data, mmem[mrd]);
      chk(stat == exp_stat(), blk ? "R5" : "R4", "stat", stat, exp_stat());
      chk(ovr == movr, "R9", "overrun", ovr, movr);
      chk(rts == mrts, "R8", "rts", rts, mrts);
   endtask

   task automatic cyc(input logic p, input logic [7:0] d, input logic [2:0] s,
                      input logic po, input logic er, input logic rr,
                      input logic sd);
      push = p; pdata = d; pstat = s; pop = po; errr = er; rxr = rr; sdet = sd;
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < DEPTH; i++) begin mmem[i] = '0; mst[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!ready && !full, "R1", "ready/full", {ready, full}, 0);
      chk(!ovr && rts, "R1", "ovr/rts", {ovr, rts}, 1);
      chk(stat == 0 && rd_data == 0, "R1", "stat/data", {stat, rd_data}, 0);

      // R6: status visible with ready on first arrival
      cyc(1, 8'hA1, 3'b010, 0, 0, 0, 0);
      chk(ready && stat == 3'b010, "R6", "ready+stat", {ready, stat}, {1'b1, 3'b010});
      // fill to full, then overrun (R9) and order (R3)
      cyc(1, 8'hB2, 3'b001, 0, 0, 0, 0);
      cyc(1, 8'hC3, 3'b100, 0, 0, 0, 0);
      chk(full, "R2", "full after three", full, 1);
      cyc(1, 8'hD4, 3'b000, 0, 0, 0, 0);
      chk(ovr && rd_data == 8'hA1, "R9", "overrun+head", {ovr, rd_data}, {1'b1, 8'hA1});
      cyc(0, 0, 0, 1, 0, 0, 0);
      chk(rd_data == 8'hB2 && stat == 3'b001, "R3", "second head", {rd_data, stat}, {8'hB2, 3'b001});
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk(!ovr, "R9", "overrun cleared", ovr, 0);

      // R5 accumulating mode
      blk = 1;
      cyc(0, 0, 0, 0, 1, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(1, 8'h11, 3'b001, 0, 0, 0, 0);
      cyc(1, 8'h22, 3'b100, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0);
      chk(stat == 3'b101, "R5", "or of heads", stat, 3'b101);
      blk = 0;

      // R7 flush keeps data
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk(!ready && stat == 0, "R7", "flush empty", {ready, stat}, 0);
      chk(rd_data == mmem[mrd], "R7", "data kept", rd_data, mmem[mrd]);
      cyc(1, 8'h5A, 3'b011, 0, 0, 0, 0);
      chk(rd_data == 8'h5A, "R7", "aligned after flush", rd_data, 8'h5A);

      // R10 empty pop misaligns
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(1, 8'h77, 3'b000, 0, 0, 0, 0);
      chk(rd_data != 8'h77 && rd_data == mmem[mrd], "R10", "stale head", rd_data, mmem[mrd]);
      cyc(0, 0, 0, 0, 0, 1, 0);

      // R8 automatic request-to-send
      auto_r = 1;
      cyc(1, 8'h01, 0, 0, 0, 0, 0);
      cyc(1, 8'h02, 0, 0, 0, 0, 0);
      cyc(1, 8'h03, 0, 0, 0, 0, 1);
      chk(rts, "R8", "rts while filling", rts, 1);
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk(!rts, "R8", "rts dropped", rts, 0);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk(rts, "R8", "rts restored", rts, 1);

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         if (k % 250 == 0) begin
            blk = 1'($urandom % 2);
            auto_r = 1'($urandom % 2);
         end
         cyc(1'($urandom % 2), 8'($urandom), 3'($urandom),
             1'(($urandom % 3) == 0), 1'(($urandom % 16) == 0),
             1'(($urandom % 64) == 0), 1'(($urandom % 4) == 0));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule